// File: doc/BRIEF.md
# Multi-Mode Serial Transceiver

This block is a full-duplex asynchronous serial transceiver. A small register bus sets up the frame, holds one character on its way out and one on its way in, and reports what happened on the line. A frame is a low start bit, then 6 to 9 data bits with the least significant bit first, then an optional extra bit, then one high stop bit. The extra bit holds either even or odd parity or, in multi-drop mode, a marker that tells an address character from a data character.

A free-running divider makes a tick at sixteen times the bit rate. The transmitter holds every bit for sixteen ticks. The receiver confirms a start bit once it has seen eight low ticks, then samples each later bit sixteen ticks apart. The receiver sets separate sticky flags for parity, framing and overrun errors and for an incoming line break. The transmitter can hold the line low to send a break. Three test modes reroute the lines: the line can be echoed from input to output, the transmitter can be looped into the receiver inside the block, or the input pin can be tied to the output pin with the receiver cut off.

Top module: `usart_core`

## Requirements
- R1: After reset, STAT (address 4) reads 0x0006, `txd_o` is 1, `irq_o` is 0 and RXD (address 3) reads 0.
- R2: Writing TXD (address 2) sends a frame on `txd_o` in normal mode. The frame is a 0 start bit, then the data bits LSB first, then a 1 stop bit. Each bit lasts 16 × max(DIV,1) clock cycles. DIV is address 1. The character length comes from CFG[1:0] at address 0: 0 selects 6 bits, 1 selects 7, 2 selects 8 and 3 selects 9. Data bits beyond the length are dropped on both sides.
- R3: CFG[3:2] selects the extra bit. A value of 1 adds an even parity bit and 2 adds an odd parity bit. A value of 0 or 3 adds no extra bit.
- R4: When the received parity bit does not match, STAT bit 3 is set and the character is still delivered.
- R5: When a stop bit is received as 0 and the frame carries at least one 1, STAT bit 4 is set and the character is still delivered.
- R6: If a character completes while STAT bit 0 (data ready) is still set, STAT bit 5 is set and RXD holds the newer character.
- R7: A frame that is 0 from the start bit through the stop bit sets STAT bit 6 and does not set the data-ready bit. The receiver then waits for the line to return high before it looks for a new start bit.
- R8: While CFG bit 7 is set, `txd_o` is held at 0 whenever no frame is being sent, and a pending character waits. Clearing the bit releases the character.
- R9: CFG bit 4 turns on multi-drop mode. The extra bit then carries TXD write bit 15, and RXD bit 15 returns the received marker. In this mode no parity is checked.
- R10: With CFG[6:5]=2 (local loop), the transmitter feeds the receiver and `txd_o` stays at 1.
- R11: With CFG[6:5]=1 (echo), `txd_o` follows `rxd_i` and the receiver still takes in characters from `rxd_i`.
- R12: With CFG[6:5]=3 (remote loop), `txd_o` follows `rxd_i` and the receiver takes in nothing.
- R13: `irq_o` is the OR of STAT[6:0] masked by IEN (address 5). STAT bits: 0 is rx ready, 1 is tx holding empty, 2 is tx idle, 3 to 6 are the error and break flags. Writing 1 to STAT bits 3 to 6 clears them. Reading RXD clears bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (has side effects only on RXD) |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data (combinational from address) |
| irq_o | output | 1 | Interrupt request |
| rxd_i | input | 1 | Serial input line |
| txd_o | output | 1 | Serial output line |

## Verification
A wrong bit counter or a wrong phase counter in the transmitter shows up on `txd_o` within one bit time, as a level that is wrong at the middle of a bit. The same fault in the receiver shows up as a wrong RXD value or a false framing flag once the frame completes, about one character time later. A wrong flag-update rule appears in STAT, and through the mask at `irq_o`, on the cycle after the character finishes. A mistake in the line routing is visible right away on `txd_o`, or in the data-ready bit after one frame.

// File: rtl/usart_pkg.sv
package usart_pkg;
  localparam int unsigned MAX_DATA = 9;
  localparam int unsigned FRAME_W  = MAX_DATA + 3;

  typedef enum logic [1:0] {MODE_NORMAL = 2'd0, MODE_ECHO = 2'd1,
                            MODE_LOCAL  = 2'd2, MODE_REMOTE = 2'd3} loop_mode_e;
  typedef enum logic [1:0] {PAR_NONE = 2'd0, PAR_EVEN = 2'd1,
                            PAR_ODD  = 2'd2, PAR_OFF  = 2'd3} par_mode_e;
  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_HOLD} rx_state_e;

  typedef struct packed {
    logic       brk_tx;
    loop_mode_e mode;
    logic       multidrop;
    par_mode_e  par;
    logic [1:0] len;
  } cfg_t;

  function automatic logic [MAX_DATA-1:0] mask_data(logic [MAX_DATA-1:0] d, logic [1:0] len);
    logic [MAX_DATA-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_DATA; i++) if (i < 6 + int'(len)) m[i] = d[i];
    return m;
  endfunction

  function automatic logic extra_en(cfg_t c);
    return c.multidrop || c.par == PAR_EVEN || c.par == PAR_ODD;
  endfunction

  function automatic logic parity_of(logic [MAX_DATA-1:0] d, par_mode_e p);
    return (p == PAR_ODD) ? ~^d : ^d;
  endfunction
endpackage

// File: rtl/usart_baud.sv
module usart_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt <= '0;
    else if (cnt == '0) cnt <= (div_i == '0) ? '0 : div_i - 1'b1;
    else cnt <= cnt - 1'b1;

  assign tick_o = (cnt == '0);
endmodule

// File: rtl/usart_tx.sv
module usart_tx
  import usart_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  cfg_t                cfg_i,
  input  logic                hold_valid_i,
  input  logic [MAX_DATA-1:0] hold_data_i,
  input  logic                hold_addr_i,
  output logic                take_o,
  output logic                busy_o,
  output logic                line_o
);
  localparam int unsigned PW = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0]  shreg, frame;
  logic [PW-1:0]       left;
  logic [3:0]          phase;
  logic [MAX_DATA-1:0] dm;
  int                  nd, nb;

  assign take_o = !busy_o && hold_valid_i && !cfg_i.brk_tx;

  always_comb begin
    nd    = 6 + int'(cfg_i.len);
    dm    = mask_data(hold_data_i, cfg_i.len);
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++) if (i < nd) frame[1+i] = dm[i];
    nb = nd + 2;
    if (extra_en(cfg_i)) begin
      frame[1+nd] = cfg_i.multidrop ? hold_addr_i : parity_of(dm, cfg_i.par);
      nb = nd + 3;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      shreg  <= '1;
      left   <= '0;
      phase  <= '0;
      busy_o <= 1'b0;
    end else if (take_o) begin
      shreg  <= frame;
      left   <= PW'(nb);
      phase  <= '0;
      busy_o <= 1'b1;
    end else if (busy_o && tick_i) begin
      if (phase == 4'd15) begin
        phase <= '0;
        shreg <= {1'b1, shreg[FRAME_W-1:1]};
        left  <= left - 1'b1;
        if (left == PW'(1)) busy_o <= 1'b0;
      end else phase <= phase + 1'b1;
    end

  // break holds the idle line low
  assign line_o = busy_o ? shreg[0] : !cfg_i.brk_tx;
endmodule

// File: rtl/usart_rx.sv
module usart_rx
  import usart_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  cfg_t                cfg_i,
  input  logic                line_i,
  output logic                done_o,
  output logic [MAX_DATA-1:0] data_o,
  output logic                addr_o,
  output logic                perr_o,
  output logic                ferr_o,
  output logic                brk_o
);
  logic [1:0]          sync;
  logic                line;
  rx_state_e           state;
  logic [3:0]          phase, pos;
  logic [FRAME_W-2:0]  bits, nxt;
  logic [MAX_DATA-1:0] dmask;
  logic                ext_b, stop_b, zero, last, ext_on, par_on;
  int                  nd, tot;

  assign line = sync[1];

  always_comb begin
    nd     = 6 + int'(cfg_i.len);
    ext_on = extra_en(cfg_i);
    par_on = !cfg_i.multidrop && ext_on;
    tot    = nd + (ext_on ? 2 : 1);
    last   = (int'(pos) == tot - 1);
    nxt    = bits;
    nxt[pos] = line;
    dmask  = mask_data(nxt[MAX_DATA-1:0], cfg_i.len);
    ext_b  = ext_on ? nxt[nd] : 1'b0;
    stop_b = nxt[tot-1];
    zero   = (dmask == '0) && !ext_b && !stop_b;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sync   <= 2'b11;
      state  <= S_IDLE;
      phase  <= '0;
      pos    <= '0;
      bits   <= '0;
      done_o <= 1'b0;
      brk_o  <= 1'b0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
      data_o <= '0;
      addr_o <= 1'b0;
    end else begin
      sync   <= {sync[0], line_i};
      done_o <= 1'b0;
      brk_o  <= 1'b0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
      unique case (state)
        S_IDLE: if (tick_i && !line) begin
          state <= S_START;
          phase <= 4'd1;
        end
        S_START: if (tick_i) begin
          if (phase == 4'd7) begin
            if (!line) begin
              state <= S_BITS;
              phase <= '0;
              pos   <= '0;
            end else state <= S_IDLE;
          end else phase <= phase + 1'b1;
        end
        S_BITS: if (tick_i) begin
          if (phase == 4'd15) begin
            phase <= '0;
            bits  <= nxt;
            pos   <= pos + 1'b1;
            if (last) begin
              state  <= stop_b ? S_IDLE : S_HOLD;
              done_o <= !zero;
              brk_o  <= zero;
              ferr_o <= !zero && !stop_b;
              perr_o <= !zero && par_on && (ext_b != parity_of(dmask, cfg_i.par));
              data_o <= dmask;
              addr_o <= cfg_i.multidrop && ext_b;
            end
          end else phase <= phase + 1'b1;
        end
        S_HOLD: if (line) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
endmodule

// File: rtl/usart_core.sv
module usart_core
  import usart_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned AW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o,
  input  logic          rxd_i,
  output logic          txd_o
);
  localparam int unsigned NSTAT = 7;
  localparam logic [AW-1:0] A_CFG  = AW'(0);
  localparam logic [AW-1:0] A_DIV  = AW'(1);
  localparam logic [AW-1:0] A_TX   = AW'(2);
  localparam logic [AW-1:0] A_RX   = AW'(3);
  localparam logic [AW-1:0] A_STAT = AW'(4);
  localparam logic [AW-1:0] A_IEN  = AW'(5);

  cfg_t                cfg;
  logic [DIV_W-1:0]    div;
  logic [NSTAT-1:0]    ien, stat;
  logic [MAX_DATA-1:0] tx_hold, rx_data, rx_d;
  logic                tx_hold_addr, tx_full, tx_take, tx_busy, tx_line;
  logic                rx_addr, rx_ready, perr_f, ferr_f, ovr_f, brk_f;
  logic                rx_done, rx_a, rx_perr, rx_ferr, rx_brk, rx_in, tick;
  logic                rd_rx;
  logic [1:0]          mode_w;

  assign mode_w = cfg.mode;
  assign rd_rx  = bus_rd_i && (bus_addr_i == A_RX);

  usart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i, .rst_ni, .div_i(div), .tick_o(tick)
  );

  usart_tx u_tx (
    .clk_i, .rst_ni, .tick_i(tick), .cfg_i(cfg),
    .hold_valid_i(tx_full), .hold_data_i(tx_hold), .hold_addr_i(tx_hold_addr),
    .take_o(tx_take), .busy_o(tx_busy), .line_o(tx_line)
  );

  usart_rx u_rx (
    .clk_i, .rst_ni, .tick_i(tick), .cfg_i(cfg), .line_i(rx_in),
    .done_o(rx_done), .data_o(rx_d), .addr_o(rx_a),
    .perr_o(rx_perr), .ferr_o(rx_ferr), .brk_o(rx_brk)
  );

  always_comb begin
    unique case (cfg.mode)
      MODE_NORMAL: begin rx_in = rxd_i; txd_o = tx_line; end
      MODE_ECHO:   begin rx_in = rxd_i; txd_o = rxd_i;   end
      MODE_LOCAL:  begin rx_in = tx_line; txd_o = 1'b1;  end
      default:     begin rx_in = 1'b1;  txd_o = rxd_i;   end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cfg          <= '0;
      div          <= '0;
      ien          <= '0;
      tx_hold      <= '0;
      tx_hold_addr <= 1'b0;
      tx_full      <= 1'b0;
      rx_data      <= '0;
      rx_addr      <= 1'b0;
      rx_ready     <= 1'b0;
      perr_f       <= 1'b0;
      ferr_f       <= 1'b0;
      ovr_f        <= 1'b0;
      brk_f        <= 1'b0;
    end else begin
      if (tx_take) tx_full <= 1'b0;
      if (bus_wr_i) begin
        unique case (bus_addr_i)
          A_CFG:  cfg <= cfg_t'(bus_wdata_i[7:0]);
          A_DIV:  div <= bus_wdata_i[DIV_W-1:0];
          A_TX: begin
            tx_hold      <= bus_wdata_i[MAX_DATA-1:0];
            tx_hold_addr <= bus_wdata_i[DW-1];
            tx_full      <= 1'b1;
          end
          A_STAT: begin
            if (bus_wdata_i[3]) perr_f <= 1'b0;
            if (bus_wdata_i[4]) ferr_f <= 1'b0;
            if (bus_wdata_i[5]) ovr_f  <= 1'b0;
            if (bus_wdata_i[6]) brk_f  <= 1'b0;
          end
          A_IEN:  ien <= bus_wdata_i[NSTAT-1:0];
          default: ;
        endcase
      end
      if (rd_rx) rx_ready <= 1'b0;
      if (rx_done) begin
        rx_data  <= rx_d;
        rx_addr  <= rx_a;
        rx_ready <= 1'b1;
        if (rx_ready) ovr_f <= 1'b1;
      end
      if (rx_perr) perr_f <= 1'b1;
      if (rx_ferr) ferr_f <= 1'b1;
      if (rx_brk)  brk_f  <= 1'b1;
    end

  assign stat  = {brk_f, ovr_f, ferr_f, perr_f, !tx_busy && !tx_full, !tx_full, rx_ready};
  assign irq_o = |(stat & ien);

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      A_CFG:  bus_rdata_o[7:0] = cfg;
      A_DIV:  bus_rdata_o[DIV_W-1:0] = div;
      A_RX: begin
        bus_rdata_o[MAX_DATA-1:0] = rx_data;
        bus_rdata_o[DW-1]         = rx_addr;
      end
      A_STAT: bus_rdata_o[NSTAT-1:0] = stat;
      A_IEN:  bus_rdata_o[NSTAT-1:0] = ien;
      default: ;
    endcase
  end
endmodule

// File: rtl/usart_core_chk.sv
module usart_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_take,
  input logic       txd_o,
  input logic [1:0] mode_w,
  input logic       rx_done,
  input logic       rx_ready,
  input logic       ovr_f,
  input logic       rd_rx,
  input logic       rx_perr,
  input logic       perr_f,
  input logic       rx_brk,
  input logic       brk_f,
  input logic       irq_o,
  input logic [6:0] ien
);
  a_r2_start_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_take && mode_w == 2'd0) |=> !txd_o);

  a_r6_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && rx_ready) |=> ovr_f);

  a_r4_parity_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_perr |=> perr_f);

  a_r7_break_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_brk |=> (brk_f && !$rose(rx_ready)));

  a_r13_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rx && !rx_done) |=> !rx_ready);

  a_r13_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien == 7'd0) |-> !irq_o);
endmodule

bind usart_core usart_core_chk u_chk (
  .clk_i, .rst_ni, .tx_take, .txd_o, .mode_w, .rx_done, .rx_ready, .ovr_f,
  .rd_rx, .rx_perr, .perr_f, .rx_brk, .brk_f, .irq_o, .ien
);

// File: tb/sim_usart_core.sv
module sim_usart_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, rxd = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        irq, txd;
  int          checks = 0, errors = 0;
  bit          finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usart_core u0 (
    .clk_i(clk), .rst_ni, .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_o(irq), .rxd_i(rxd), .txd_o(txd)
  );

  // {len[1:0], par[1:0], multidrop, addr, data[8:0]}
  localparam logic [14:0] VEC [8] = '{
    {2'd0, 2'd1, 1'b0, 1'b0, 9'h1EA},
    {2'd1, 2'd2, 1'b0, 1'b0, 9'h055},
    {2'd2, 2'd0, 1'b0, 1'b0, 9'h0A5},
    {2'd3, 2'd0, 1'b0, 1'b0, 9'h1FF},
    {2'd3, 2'd1, 1'b0, 1'b0, 9'h100},
    {2'd2, 2'd2, 1'b0, 1'b0, 9'h000},
    {2'd3, 2'd0, 1'b1, 1'b1, 9'h1A5},
    {2'd2, 2'd0, 1'b1, 1'b0, 9'h0F3}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_ready(input int limit);
    bus_addr = 3'd4;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (bus_rdata[0]) break;
    end
  endtask

  task automatic wait_tx_idle();
    bus_addr = 3'd4;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (bus_rdata[2]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic send_rx(input logic [11:0] fb, input int n);
    for (int i = 0; i < n; i++) begin
      rxd = fb[i];
      repeat (16) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, exp;
    logic [9:0]  tb_bits;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd4, d); chk("R1 status", d, 16'h0006);
    rd(3'd3, d); chk("R1 rxdata", d, 16'h0000);
    chk("R1 txd", {15'd0, txd}, 16'd1);
    chk("R1 irq", {15'd0, irq}, 16'd0);

    wr(3'd1, 16'd1);

    // R2 R3 R9 R10: vector table in local loop
    foreach (VEC[k]) begin
      logic [1:0] len; logic [1:0] par; logic md, ad; logic [8:0] dat;
      {len, par, md, ad, dat} = VEC[k];
      wr(3'd0, {8'd0, 1'b0, 2'd2, md, par, len});
      wr(3'd2, {ad, 6'd0, dat});
      chk("R10 txd high in local loop", {15'd0, txd}, 16'd1);
      wait_ready(600);
      rd(3'd4, d);
      chk("R4 R5 no error on loop", d & 16'h0018, 16'h0000);
      exp = {md & ad, 6'd0, dat & 9'((1 << (6 + int'(len))) - 1)};
      rd(3'd3, d);
      chk("R2 R3 R9 loop data", d, exp);
      wait_tx_idle();
    end

    // R2 bit timing, 8N1 data 0x4B, DIV=3
    wr(3'd0, 16'h0002);
    wr(3'd1, 16'd3);
    wr(3'd2, 16'h004B);
    tb_bits = {1'b1, 8'h4B, 1'b0};
    repeat (24) @(negedge clk);
    for (int b = 0; b < 10; b++) begin
      chk("R2 tx bit level", {15'd0, txd}, {15'd0, tb_bits[b]});
      repeat (48) @(negedge clk);
    end
    wait_tx_idle();
    wr(3'd1, 16'd1);

    // R4 parity error: even parity, 8 bits, data 0x35 has even ones -> parity 0, send 1
    wr(3'd0, 16'h0006);
    send_rx({1'b1, 1'b1, 8'h35, 1'b0}, 11);
    rd(3'd4, d); chk("R4 parity flag", d & 16'h0019, 16'h0009);
    rd(3'd3, d); chk("R4 data kept", d, 16'h0035);
    wr(3'd4, 16'h0008);
    rd(3'd4, d); chk("R13 W1C parity", d & 16'h0009, 16'h0000);

    // R5 framing error
    wr(3'd0, 16'h0002);
    send_rx({2'b00, 8'h3C, 1'b0}, 10);
    rd(3'd4, d); chk("R5 framing flag", d & 16'h0011, 16'h0011);
    rd(3'd3, d); chk("R5 data kept", d, 16'h003C);
    wr(3'd4, 16'h0010);

    // R7 break detect
    send_rx(12'h000, 10);
    rd(3'd4, d); chk("R7 break flag, no data", d & 16'h0051, 16'h0040);
    wr(3'd4, 16'h0040);

    // R6 overrun in local loop
    wr(3'd0, 16'h0042);
    wr(3'd2, 16'h0011);
    wr(3'd2, 16'h0022);
    repeat (420) @(negedge clk);
    rd(3'd4, d); chk("R6 overrun flag", d & 16'h0021, 16'h0021);
    rd(3'd3, d); chk("R6 newer data", d, 16'h0022);
    wr(3'd4, 16'h0020);

    // R11 echo + R13 irq
    wr(3'd0, 16'h0022);
    wr(3'd5, 16'h0001);
    rxd = 1'b0; #1;
    chk("R11 echo low", {15'd0, txd}, 16'd0);
    rxd = 1'b1; #1;
    chk("R11 echo high", {15'd0, txd}, 16'd1);
    send_rx({1'b1, 8'h9C, 1'b0}, 10);
    chk("R13 irq on ready", {15'd0, irq}, 16'd1);
    rd(3'd3, d); chk("R11 echo rx data", d, 16'h009C);
    @(negedge clk);
    chk("R13 irq after read", {15'd0, irq}, 16'd0);
    wr(3'd5, 16'h0000);

    // R12 remote loop
    wr(3'd0, 16'h0062);
    rxd = 1'b0; #1;
    chk("R12 remote follows", {15'd0, txd}, 16'd0);
    rxd = 1'b1;
    send_rx({1'b1, 8'h5A, 1'b0}, 10);
    rd(3'd4, d); chk("R12 receiver cut off", d & 16'h0001, 16'h0000);

    // R8 break generation
    wr(3'd0, 16'h0082);
    repeat (3) @(negedge clk);
    chk("R8 line held low", {15'd0, txd}, 16'd0);
    wr(3'd2, 16'h0077);
    repeat (40) @(negedge clk);
    rd(3'd4, d); chk("R8 char waits", d & 16'h0006, 16'h0000);
    chk("R8 still low", {15'd0, txd}, 16'd0);
    wr(3'd0, 16'h0002);
    repeat (3) @(negedge clk);
    rd(3'd4, d); chk("R8 char released", d & 16'h0002, 16'h0002);
    wait_tx_idle();
    chk("R8 idle high", {15'd0, txd}, 16'd1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule